// File: doc/BRIEF.md
# Bit-serial by parallel unsigned multiplier

The block multiplies an M-bit unsigned operand, held in parallel, by an N-bit unsigned operand that arrives one bit per clock, least significant bit first. A start pulse captures the parallel operand and clears all internal sum, carry and product state. In each following cycle the current serial bit is ANDed with every bit of the held operand. The resulting partial-product bits are added into a row of M registered full-adder cells. That row keeps carries and shifted sums in carry-save form. One column of the partial-product matrix is finished per cycle.

The finished column bit leaves the block on a serial output. It is also shifted into a product register. After N cycles of real serial data, the block forces M further zero columns internally, so that the stored carries drain. The whole (M+N)-bit product is then in the register, and a one-cycle valid flag marks it. Area stays at one row of adder cells, at the price of M+N cycles per product.

Top module: `sp_mult`

## Requirements
- R1: While rst_ni is low, and in the cycles after it rises until the first start, prod_o, prod_bit_o and valid_o are all zero.
- R2: A cycle with start_i high (cycle S) captures mcand_i and clears every stored sum, carry and product bit. In cycle S+1, prod_o reads zero and valid_o is low. Changes to mcand_i after cycle S have no effect on the result.
- R3: ser_bit_i is sampled in cycles S+1 .. S+N, where bit k of the serial operand is taken in cycle S+1+k. When valid_o is high, prod_o equals the unsigned product mcand * serial operand, M+N bits wide.
- R4: valid_o is high for exactly one cycle, S+M+N+1, for each operation that runs to completion.
- R5: prod_bit_o carries product bit k in cycle S+k+2, least significant bit first. In every such cycle it equals prod_o[M+N-1].
- R6: During the M flush cycles S+N+1 .. S+N+M, ser_bit_i is ignored and zero is used in its place.
- R7: After completion, and until the next start, prod_o holds the product and ser_bit_i has no effect.
- R8: A start during a running operation abandons that operation without a valid pulse and begins the new one from a cleared state.
- R9: The all-ones operands give the full-width product with no truncation of the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load the parallel operand and begin a new product |
| mcand_i | input | A_W | Parallel operand, captured on start |
| ser_bit_i | input | 1 | Serial operand bit, least significant first |
| prod_bit_o | output | 1 | Serial product bit, least significant first |
| prod_o | output | A_W+B_W | Collected product |
| valid_o | output | 1 | One-cycle flag: prod_o is complete |

## Verification
The bound checker watches several properties on every cycle. It checks that valid_o is a single-cycle pulse that lands exactly M+N+1 cycles after the start that began the run. It checks that a start always clears the product and suppresses valid, that the serial output tracks the top bit of the product register throughout a run, and that the product stays frozen once complete. Only the bench's scenarios can show the arithmetic itself. That covers correct products across operand patterns and the all-ones extreme, flush cycles that ignore a driven-high serial input, a held operand unaffected by later changes on mcand_i, and an aborted run that leaves no trace in the next result.

// File: rtl/sp_mult_pkg.sv
package sp_mult_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

  // full add: {carry, sum}
  function automatic logic [1:0] fa3(input logic x, input logic y, input logic z);
    return {(x & y) | (y & z) | (x & z), x ^ y ^ z};
  endfunction
endpackage

// File: rtl/sp_mult_ctrl.sv
module sp_mult_ctrl
  import sp_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic run_o,
  output logic feed_o,
  output logic last_o
);
  localparam int TOT = A_W + B_W;
  localparam int CW  = $clog2(TOT + 1);

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;

  assign run_o  = (phase_q == PH_RUN);
  assign feed_o = run_o && (cnt_q < CW'(B_W));
  assign last_o = run_o && (cnt_q == CW'(TOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else if (run_o) begin
      if (last_o) phase_q <= PH_IDLE;
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sp_mult_cell.sv
module sp_mult_cell
  import sp_mult_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic pp_i,
  input  logic sum_up_i,
  output logic sum_o
);
  logic       s_q, c_q;
  logic [1:0] add;

  assign add   = fa3(pp_i, s_q, c_q);
  assign sum_o = add[0];

  // sum moves one column down, carry stays (its weight drops with the shift)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (clr_i) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else if (en_i) begin
      s_q <= sum_up_i;
      c_q <= add[1];
    end
  end
endmodule

// File: rtl/sp_mult_row.sv
module sp_mult_row #(
  parameter int A_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [A_W-1:0] pp_i,
  output logic           col_o
);
  logic [A_W:0] sum_w;

  assign sum_w[A_W] = 1'b0;
  assign col_o      = sum_w[0];

  for (genvar j = 0; j < A_W; j++) begin : g_cell
    sp_mult_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .en_i     (en_i),
      .pp_i     (pp_i[j]),
      .sum_up_i (sum_w[j+1]),
      .sum_o    (sum_w[j])
    );
  end
endmodule

// File: rtl/sp_mult.sv
module sp_mult #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [A_W-1:0]     mcand_i,
  input  logic               ser_bit_i,
  output logic               prod_bit_o,
  output logic [A_W+B_W-1:0] prod_o,
  output logic               valid_o
);
  localparam int W = A_W + B_W;

  logic           run, feed, last, col;
  logic [A_W-1:0] mcand_q, pp;
  logic [W-1:0]   prod_q;
  logic           bit_q, valid_q;

  sp_mult_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .run_o   (run),
    .feed_o  (feed),
    .last_o  (last)
  );

  assign pp = mcand_q & {A_W{feed & ser_bit_i}};

  sp_mult_row #(.A_W(A_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (run),
    .pp_i   (pp),
    .col_o  (col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= run & last & ~start_i;
      if (start_i) begin
        mcand_q <= mcand_i;
        prod_q  <= '0;
        bit_q   <= 1'b0;
      end else if (run) begin
        prod_q <= {col, prod_q[W-1:1]};
        bit_q  <= col;
      end
    end
  end

  assign prod_o     = prod_q;
  assign prod_bit_o = bit_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/sp_mult_chk.sv
module sp_mult_chk #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               prod_bit_o,
  input logic [A_W+B_W-1:0] prod_o,
  input logic               valid_o
);
  localparam int TOT = A_W + B_W;
  localparam int CW  = $clog2(TOT + 3);

  logic          armed_q, held_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      held_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (start_i) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
        held_q  <= 1'b0;
      end else begin
        if (valid_o) held_q <= 1'b1;
        if (armed_q) begin
          if (cnt_q == CW'(TOT + 1)) armed_q <= 1'b0;
          else cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !held_q) |-> (!valid_o && prod_o == '0));

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (prod_o == '0 && !valid_o));

  p_valid_when_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (armed_q && cnt_q == CW'(TOT + 1)));

  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_bit_tracks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cnt_q >= CW'(2)) |-> (prod_bit_o == prod_o[TOT-1]));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_o || held_q) && !start_i) |=> $stable(prod_o));
endmodule

bind sp_mult sp_mult_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .prod_bit_o (prod_bit_o),
  .prod_o     (prod_o),
  .valid_o    (valid_o)
);

// File: tb/sp_mult_bench.sv
module sp_mult_bench;
  localparam int A_W = 8;
  localparam int B_W = 6;
  localparam int W   = A_W + B_W;
  localparam int NV  = 8;
  // each entry: {mcand, serial operand}
  localparam logic [W-1:0] VEC [NV] = '{
    {8'h00, 6'h2a}, {8'h5a, 6'h00}, {8'h01, 6'h01}, {8'h80, 6'h20},
    {8'ha5, 6'h15}, {8'h3c, 6'h3f}, {8'hff, 6'h01}, {8'h7e, 6'h2b}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [A_W-1:0] mcand = '0;
  logic           ser = 1'b0;
  logic           prod_bit;
  logic [W-1:0]   prod;
  logic           valid;
  int             errors = 0;
  int             checks = 0;

  always #2 clk = ~clk;

  sp_mult #(.A_W(A_W), .B_W(B_W)) u_sp_mult (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .mcand_i    (mcand),
    .ser_bit_i  (ser),
    .prod_bit_o (prod_bit),
    .prod_o     (prod),
    .valid_o    (valid)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_op(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                        input bit flush_ones, input string req);
    logic [W-1:0] exp;
    int bad;
    exp = W'(a) * W'(b);
    bad = 0;
    @(negedge clk);
    start = 1'b1; mcand = a; ser = 1'b0;
    @(negedge clk);
    start = 1'b0; mcand = ~a;  // R2: later operand changes ignored
    chk(prod == '0 && !valid, "R2 clear after start", prod, '0);
    for (int j = 0; j < W; j++) begin
      if (j > 0) begin
        @(negedge clk);
        if (prod_bit !== exp[j-1] || valid) bad++;
      end
      ser = (j < B_W) ? b[j] : flush_ones;
    end
    @(negedge clk);
    if (prod_bit !== exp[W-1]) bad++;
    chk(bad == 0, "R5 serial product bits", W'(bad), '0);
    chk(valid === 1'b1, {req, " R4 valid timing"}, W'(valid), W'(1));
    chk(prod === exp, {req, " R3 product"}, prod, exp);
    ser = ~ser;
    @(negedge clk);
    chk(valid === 1'b0, "R4 single pulse", W'(valid), '0);
    ser = 1'b1;
    repeat (3) @(negedge clk);
    chk(prod === exp && !valid, "R7 hold while idle", prod, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(prod == '0 && !valid && !prod_bit, "R1 in reset", prod, '0);
    rst_n = 1'b1;
    ser = 1'b1;
    repeat (3) @(negedge clk);
    chk(prod == '0 && !valid && !prod_bit, "R1 after reset", prod, '0);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][W-1:B_W], VEC[i][B_W-1:0], 1'b0, "R3 vector");

    // R6: serial input driven high during flush
    run_op(8'h93, 6'h2d, 1'b1, "R6 flush ignored");
    // R9: extremes
    run_op(8'hff, 6'h3f, 1'b1, "R9 all ones");

    // R8: abandon a run half way
    @(negedge clk);
    start = 1'b1; mcand = 8'hff; ser = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    run_op(8'h11, 6'h05, 1'b0, "R8 restart");

    // R1: reset in the middle of a run
    @(negedge clk);
    start = 1'b1; mcand = 8'hc3; ser = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(prod == '0 && !valid && !prod_bit, "R1 async reset", prod, '0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (W + 4) begin
        @(negedge clk);
        if (valid || prod != '0) seen++;
      end
      chk(seen == 0, "R1 no valid after reset abort", W'(seen), '0);
    end

    report();
    $finish;
  end
endmodule